// File: doc/BRIEF.md
# Charger Control Source Arbiter

The block picks the source for three charger control settings: the input current limit, a combined off switch for the linear regulator and the charger, and charge enable. Each setting can come from a strap pin or from a register field. After reset every setting follows its pin.

A write strobe on a field hands that one setting to the register, and the pin for that setting is then ignored. The other settings stay with their pins. When the input supply is plugged in or pulled out, all three settings go back to pin control. The supply-good input and the strap pins are asynchronous, so each one passes through a synchronizer. A pin that is left floating is taken to read low.

The current limit is a three-bit code. Code 0 is 100 mA, 1 is 150 mA, 2 is 300 mA, 3 is 500 mA, 4 is 900 mA and 5 is 1500 mA.

Top module: `chg_ctl_arbiter`

## Requirements
- R1: While reset is held, and after it is released, no setting is register-owned. With all pins low and supply-good low, `lim_code`=0, `ldo_chg_off`=0 and `chg_en`=0.
- R2: When current-limit control is pin-owned, `pin_lim` low gives `lim_code`=0 (100 mA) and `pin_lim` high gives `lim_code`=3 (500 mA).
- R3: When off control is pin-owned, `ldo_chg_off` equals `pin_off`: high means the regulator and the charger are off, and low means normal operation.
- R4: When charge enable is pin-owned, `chg_en` equals `pin_chg`: high means charging is on, and low means it is off.
- R5: A pin change reaches the output after exactly SYNC_STAGES rising clock edges. After SYNC_STAGES-1 edges the output still shows the old value.
- R6: A write strobe sampled at a rising edge, with no supply event at that edge, makes that setting register-owned. The written value appears right after that edge, and the setting's pin no longer has any effect.
- R7: A written current-limit code above 5 is stored and shown as 5 (1500 mA). Codes 0 to 5 are kept as written.
- R8: A write to one setting leaves the other two settings under their current owner.
- R9: A rise or a fall of `vin_ok` returns all three settings to pin control. The outputs follow the pins again after SYNC_STAGES+1 rising edges.
- R10: If a write strobe falls in the same cycle as a detected supply event, the supply event wins. The write is discarded and the setting stays pin-driven.
- R11: A register-owned setting keeps its value until the next write to it or the next supply event. A later write replaces the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_ok | input | 1 | Asynchronous input-supply-good level |
| pin_lim | input | 1 | Current-limit strap pin (floating reads low) |
| pin_off | input | 1 | Regulator/charger off strap pin |
| pin_chg | input | 1 | Charge enable strap pin |
| wr_lim | input | 1 | Write strobe for the current-limit field |
| wr_lim_code | input | LIM_W | Current-limit code to write |
| wr_off | input | 1 | Write strobe for the off field |
| wr_off_val | input | 1 | Off value to write |
| wr_chg | input | 1 | Write strobe for the charge enable field |
| wr_chg_val | input | 1 | Charge enable value to write |
| lim_code | output | LIM_W | Resolved current-limit code |
| ldo_chg_off | output | 1 | Resolved regulator and charger off flag |
| chg_en | output | 1 | Resolved charge enable flag |

## Verification
The bench builds the block with its defaults: two synchronizer stages and a three-bit limit code with 5 as the top code. With this setup all eight pin patterns can be swept, and every writable code can be tried, including 6 and 7, which must saturate. The short synchronizer means the exact latency edge and the cycle where a write meets a supply event can be placed by counting a few clock edges. Supply rises and falls are each tested against owned settings.

// File: rtl/chg_ctl_arbiter.sv
module chg_ctl_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int LIM_W       = 3,
  parameter int LIM_PIN_LO  = 0,
  parameter int LIM_PIN_HI  = 3,
  parameter int LIM_MAX     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vin_ok,
  input  logic             pin_lim,
  input  logic             pin_off,
  input  logic             pin_chg,
  input  logic             wr_lim,
  input  logic [LIM_W-1:0] wr_lim_code,
  input  logic             wr_off,
  input  logic             wr_off_val,
  input  logic             wr_chg,
  input  logic             wr_chg_val,
  output logic [LIM_W-1:0] lim_code,
  output logic             ldo_chg_off,
  output logic             chg_en
);
  localparam int TOP = SYNC_STAGES - 1;
  localparam logic [LIM_W-1:0] CODE_LO  = LIM_W'(LIM_PIN_LO);
  localparam logic [LIM_W-1:0] CODE_HI  = LIM_W'(LIM_PIN_HI);
  localparam logic [LIM_W-1:0] CODE_MAX = LIM_W'(LIM_MAX);

  logic [TOP:0] vin_sq, lim_sq, off_sq, chg_sq;
  logic vin_prev, vin_evt;
  logic own_lim, own_off, own_chg;
  logic [LIM_W-1:0] lim_reg;
  logic off_reg, chg_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vin_sq   <= '0;
      lim_sq   <= '0;
      off_sq   <= '0;
      chg_sq   <= '0;
      vin_prev <= 1'b0;
    end else begin
      vin_sq   <= {vin_sq[TOP-1:0], vin_ok};
      lim_sq   <= {lim_sq[TOP-1:0], pin_lim};
      off_sq   <= {off_sq[TOP-1:0], pin_off};
      chg_sq   <= {chg_sq[TOP-1:0], pin_chg};
      vin_prev <= vin_sq[TOP];
    end
  end

  assign vin_evt = vin_sq[TOP] ^ vin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_lim <= 1'b0;
      own_off <= 1'b0;
      own_chg <= 1'b0;
      lim_reg <= '0;
      off_reg <= 1'b0;
      chg_reg <= 1'b0;
    end else if (vin_evt) begin
      own_lim <= 1'b0;
      own_off <= 1'b0;
      own_chg <= 1'b0;
    end else begin
      if (wr_lim) begin
        own_lim <= 1'b1;
        lim_reg <= (wr_lim_code > CODE_MAX) ? CODE_MAX : wr_lim_code;
      end
      if (wr_off) begin
        own_off <= 1'b1;
        off_reg <= wr_off_val;
      end
      if (wr_chg) begin
        own_chg <= 1'b1;
        chg_reg <= wr_chg_val;
      end
    end
  end

  assign lim_code    = own_lim ? lim_reg : (lim_sq[TOP] ? CODE_HI : CODE_LO);
  assign ldo_chg_off = own_off ? off_reg : off_sq[TOP];
  assign chg_en      = own_chg ? chg_reg : chg_sq[TOP];
endmodule

module chg_ctl_arbiter_chk #(
  parameter int LIM_W      = 3,
  parameter int LIM_PIN_LO = 0,
  parameter int LIM_PIN_HI = 3,
  parameter int LIM_MAX    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vin_evt,
  input logic             wr_lim,
  input logic             wr_off,
  input logic             wr_chg,
  input logic             own_lim,
  input logic             own_off,
  input logic             own_chg,
  input logic [LIM_W-1:0] lim_code
);
  assert_supply_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vin_evt |=> !(own_lim || own_off || own_chg));
  assert_supply_beats_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vin_evt && (wr_lim || wr_off || wr_chg)) |=> !(own_lim || own_off || own_chg));
  assert_write_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lim && !vin_evt) |=> own_lim);
  assert_one_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lim && !wr_off && !wr_chg && !vin_evt && !own_off && !own_chg) |=> (!own_off && !own_chg));
  assert_pin_codes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !own_lim |-> (lim_code == LIM_W'(LIM_PIN_LO) || lim_code == LIM_W'(LIM_PIN_HI)));
  assert_code_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lim_code <= LIM_W'(LIM_MAX));
  assert_owned_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (own_lim && !wr_lim && !vin_evt) |=> $stable(lim_code));
endmodule

bind chg_ctl_arbiter chg_ctl_arbiter_chk #(
  .LIM_W(LIM_W), .LIM_PIN_LO(LIM_PIN_LO), .LIM_PIN_HI(LIM_PIN_HI), .LIM_MAX(LIM_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vin_evt(vin_evt),
  .wr_lim(wr_lim), .wr_off(wr_off), .wr_chg(wr_chg),
  .own_lim(own_lim), .own_off(own_off), .own_chg(own_chg),
  .lim_code(lim_code)
);

// File: tb/tb_chg_ctl_arbiter.sv
module tb_chg_ctl_arbiter;
  localparam int S = 2;
  localparam int W = 3;

  logic clk = 1'b0, rst_n = 1'b0, vin_ok = 1'b0;
  logic pin_lim = 0, pin_off = 0, pin_chg = 0;
  logic wr_lim = 0, wr_off = 0, wr_chg = 0;
  logic [W-1:0] wr_lim_code = '0;
  logic wr_off_val = 0, wr_chg_val = 0;
  logic [W-1:0] lim_code;
  logic ldo_chg_off, chg_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chg_ctl_arbiter #(.SYNC_STAGES(S), .LIM_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok),
    .pin_lim(pin_lim), .pin_off(pin_off), .pin_chg(pin_chg),
    .wr_lim(wr_lim), .wr_lim_code(wr_lim_code),
    .wr_off(wr_off), .wr_off_val(wr_off_val),
    .wr_chg(wr_chg), .wr_chg_val(wr_chg_val),
    .lim_code(lim_code), .ldo_chg_off(ldo_chg_off), .chg_en(chg_en));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pin_code(logic p);
    return p ? 3 : 0;
  endfunction

  function automatic int sat(int c);
    return (c > 5) ? 5 : c;
  endfunction

  task automatic settle();
    repeat (S + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_lim(int c);
    wr_lim = 1; wr_lim_code = W'(c);
    @(negedge clk);
    wr_lim = 0;
  endtask

  task automatic pulse_off_chg(logic o, logic c);
    wr_off = 1; wr_off_val = o; wr_chg = 1; wr_chg_val = c;
    @(negedge clk);
    wr_off = 0; wr_chg = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lim in reset", lim_code, 0);
    rst_n = 1;
    settle();
    chk("R1 lim", lim_code, 0);
    chk("R1 off", ldo_chg_off, 0);
    chk("R1 chg", chg_en, 0);

    // R5 latency
    pin_lim = 1;
    repeat (S - 1) @(posedge clk);
    @(negedge clk);
    chk("R5 before latency", lim_code, 0);
    @(posedge clk); @(negedge clk);
    chk("R5 at latency", lim_code, 3);

    // R2 R3 R4 sweep
    for (int p = 0; p < 8; p++) begin
      {pin_lim, pin_off, pin_chg} = 3'(p);
      settle();
      chk("R2 pin lim", lim_code, pin_code(pin_lim));
      chk("R3 pin off", ldo_chg_off, pin_off);
      chk("R4 pin chg", chg_en, pin_chg);
    end

    // R6 R7 R8 writes
    {pin_lim, pin_off, pin_chg} = 3'b000;
    settle();
    for (int c = 0; c < 8; c++) begin
      pulse_lim(c);
      chk("R7 written code", lim_code, sat(c));
      chk("R8 off untouched", ldo_chg_off, 0);
      chk("R8 chg untouched", chg_en, 0);
    end
    pin_lim = 1; pin_off = 1; pin_chg = 1;
    settle();
    chk("R6 lim pin ignored", lim_code, 5);
    chk("R8 off still pin", ldo_chg_off, 1);
    chk("R8 chg still pin", chg_en, 1);
    pulse_off_chg(0, 0);
    chk("R6 off written", ldo_chg_off, 0);
    chk("R6 chg written", chg_en, 0);
    pin_lim = 0; pin_off = 0; pin_chg = 1;
    settle();
    chk("R11 lim held", lim_code, 5);
    chk("R11 off held", ldo_chg_off, 0);
    chk("R11 chg held", chg_en, 0);
    pulse_lim(2);
    chk("R11 lim rewritten", lim_code, 2);

    // R9 rise
    pin_lim = 1; pin_off = 1; pin_chg = 1;
    vin_ok = 1;
    settle();
    chk("R9 rise lim", lim_code, 3);
    chk("R9 rise off", ldo_chg_off, 1);
    chk("R9 rise chg", chg_en, 1);

    // R9 fall
    pulse_lim(4);
    pulse_off_chg(0, 0);
    chk("R6 lim owned again", lim_code, 4);
    vin_ok = 0;
    settle();
    chk("R9 fall lim", lim_code, 3);
    chk("R9 fall off", ldo_chg_off, 1);
    chk("R9 fall chg", chg_en, 1);

    // R10 conflict
    vin_ok = 1;
    repeat (S) @(posedge clk);
    @(negedge clk);
    wr_lim = 1; wr_lim_code = 3'd5;
    wr_off = 1; wr_off_val = 0;
    @(negedge clk);
    wr_lim = 0; wr_off = 0;
    chk("R10 lim stays pin", lim_code, 3);
    chk("R10 off stays pin", ldo_chg_off, 1);
    pin_lim = 0; pin_off = 0;
    settle();
    chk("R10 lim follows pin", lim_code, 0);
    chk("R10 off follows pin", ldo_chg_off, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule